// File: doc/BRIEF.md
# Seconds Counter with Alarm Interrupt

This peripheral keeps a 32-bit count of elapsed seconds and raises a level interrupt when that count reaches a programmed alarm value. A prescaler divides the system clock by `CLKS_PER_SEC` to produce a one-second tick. The count wraps freely from all ones back to zero, and the alarm compare follows the wrap without special handling.

Software reaches the block over a plain 32-bit register bus that has a byte address, separate read and write strobes, and write data. Read data is combinational and is valid in the same cycle as the read strobe. Writes take effect at the next clock edge. The block decodes a 4 KB window, of which address bits [1:0] are ignored. Through this window software can:
- read the live count,
- load a new count,
- set the alarm,
- mask the interrupt,
- inspect raw and masked status,
- clear the status.

The top of the window returns eight fixed identification bytes.

Top module: `sec_alarm_clock`

## Requirements
- R1: After reset the count, alarm, load-readback, mask and raw status all read 0, and `irqOut` is low.
- R2: The count increases by one every `CLKS_PER_SEC` clock cycles and wraps from 0xFFFFFFFF to 0. It is read at offset 0x00.
- R3: A write to offset 0x08 sets the count to the written data and restarts the prescaler, so the next increment comes a full `CLKS_PER_SEC` cycles later. A read of 0x08 returns the last value written there.
- R4: Offset 0x04 holds the alarm value and reads back what was written.
- R5: When an increment makes the count equal the alarm value, the raw status bit (offset 0x14, bit 0) sets. This includes an increment that wraps through zero.
- R6: A write to 0x04 or 0x08 compares the new count and alarm at once. If they are equal, raw status sets at that same edge.
- R7: Offset 0x0C always reads 1, and writes to it change nothing.
- R8: A write to 0x10 stores only data bit 0 as the mask, and reads of 0x10 return that single bit.
- R9: A write of any data to 0x1C clears raw status. If status is set in the same cycle, the set wins.
- R10: `irqOut` equals raw status AND mask. Offset 0x18 reads the same value.
- R11: Offsets 0xFE0 to 0xFFC return, one word each in rising address order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with upper bits zero.
- R12: Reads of 0x1C and of unmapped offsets return 0. Writes to 0x00, 0x14, 0x18 and unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address within the window |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while `busRd` is high, otherwise 0 |
| irqOut | output | 1 | Level alarm interrupt |

## Verification
The bench builds the block with `CLKS_PER_SEC` set to 4. A one-second tick then takes four clocks, so a single run can cover many ticks, a wrap from 0xFFFFFFFF to zero, and a status clear aligned exactly with a tick edge. The short period also lets the bench predict the prescaler phase after every load and place writes on chosen edges. The default divider is far too long to simulate, but it uses the same prescaler path, which is a plain compare against a parameter.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int DATA_W = 32;

  // word offsets (byte offset >> 2)
  localparam logic [9:0] OFS_COUNT = 10'h000;
  localparam logic [9:0] OFS_ALARM = 10'h001;
  localparam logic [9:0] OFS_LOAD  = 10'h002;
  localparam logic [9:0] OFS_CTRL  = 10'h003;
  localparam logic [9:0] OFS_MASK  = 10'h004;
  localparam logic [9:0] OFS_RAW   = 10'h005;
  localparam logic [9:0] OFS_MSKD  = 10'h006;
  localparam logic [9:0] OFS_CLR   = 10'h007;

  typedef struct packed {
    logic loadWr;
    logic alarmWr;
    logic maskWr;
    logic clearWr;
  } sac_strobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] alarmVal;
    logic [DATA_W-1:0] loadVal;
    logic              maskBit;
    logic              rawStat;
  } sac_view_t;
endpackage

// File: rtl/sac_datapath.sv
module sac_datapath
  import sac_pkg::*;
#(
  parameter int CLKS_PER_SEC = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  sac_strobe_t       strb,
  input  logic [DATA_W-1:0] wdata,
  output sac_view_t         view,
  output logic              irq
);
  localparam int PRE_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;

  logic              secEdge;
  logic              tick;
  logic [DATA_W-1:0] count, alarmVal, loadVal;
  logic              maskBit, rawStat;
  logic [DATA_W-1:0] cntNext, alarmNext;
  logic              setEv;

  generate
    if (CLKS_PER_SEC <= 1) begin : g_noPre
      assign secEdge = 1'b1;
    end else begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strb.loadWr || secEdge) preCnt <= '0;
        else                                 preCnt <= preCnt + 1'b1;
      end
      assign secEdge = (preCnt == PRE_W'(CLKS_PER_SEC - 1));
    end
  endgenerate

  assign tick      = secEdge && !strb.loadWr;
  assign cntNext   = strb.loadWr ? wdata : (tick ? count + 1'b1 : count);
  assign alarmNext = strb.alarmWr ? wdata : alarmVal;
  assign setEv     = (strb.loadWr || strb.alarmWr || tick) && (cntNext == alarmNext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      alarmVal <= '0;
      loadVal  <= '0;
      maskBit  <= 1'b0;
      rawStat  <= 1'b0;
    end else begin
      count    <= cntNext;
      alarmVal <= alarmNext;
      if (strb.loadWr) loadVal <= wdata;
      if (strb.maskWr) maskBit <= wdata[0];
      if (setEv)             rawStat <= 1'b1;
      else if (strb.clearWr) rawStat <= 1'b0;
    end
  end

  assign irq  = rawStat & maskBit;
  assign view = '{count: count, alarmVal: alarmVal, loadVal: loadVal,
                  maskBit: maskBit, rawStat: rawStat};

  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWr |=> count == $past(wdata));
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (secEdge && !strb.loadWr) |=> count == $past(count) + 1'b1);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!secEdge && !strb.loadWr) |=> $stable(count));
  p_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count + 1'b1 == alarmNext) |=> rawStat);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearWr && !setEv) |=> !rawStat);
endmodule

// File: rtl/sac_ctrl.sv
module sac_ctrl
  import sac_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  sac_view_t         view,
  output sac_strobe_t       strb,
  output logic [DATA_W-1:0] busRdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              inIdWin;
  logic [2:0]        idIdx;
  logic [DATA_W-1:0] rdMux;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h31;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h14;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

  assign word    = busAddr[ADDR_W-1:2];
  assign inIdWin = &busAddr[ADDR_W-1:5];
  assign idIdx   = busAddr[4:2];

  always_comb begin
    strb = '0;
    if (busWr) begin
      case (word)
        WORD_W'(OFS_LOAD):  strb.loadWr  = 1'b1;
        WORD_W'(OFS_ALARM): strb.alarmWr = 1'b1;
        WORD_W'(OFS_MASK):  strb.maskWr  = 1'b1;
        WORD_W'(OFS_CLR):   strb.clearWr = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdMux = '0;
    if (inIdWin) rdMux = DATA_W'(idByte(idIdx));
    else begin
      case (word)
        WORD_W'(OFS_COUNT): rdMux = view.count;
        WORD_W'(OFS_ALARM): rdMux = view.alarmVal;
        WORD_W'(OFS_LOAD):  rdMux = view.loadVal;
        WORD_W'(OFS_CTRL):  rdMux = DATA_W'(1);
        WORD_W'(OFS_MASK):  rdMux = DATA_W'(view.maskBit);
        WORD_W'(OFS_RAW):   rdMux = DATA_W'(view.rawStat);
        WORD_W'(OFS_MSKD):  rdMux = DATA_W'(view.rawStat & view.maskBit);
        default:            rdMux = '0;
      endcase
    end
  end

  assign busRdata = busRd ? rdMux : '0;

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadWr, strb.alarmWr, strb.maskWr, strb.clearWr}));
  p_no_strobe_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |-> strb == '0);
endmodule

// File: rtl/sec_alarm_clock.sv
module sec_alarm_clock
  import sac_pkg::*;
#(
  parameter int CLKS_PER_SEC = 50_000_000,
  parameter int ADDR_W       = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);
  sac_strobe_t strb;
  sac_view_t   view;

  sac_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .view(view), .strb(strb), .busRdata(busRdata)
  );

  sac_datapath #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .view(view), .irq(irqOut)
  );

  p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> view.maskBit && view.rawStat);
endmodule

// File: tb/test_sec_alarm_clock.sv
module test_sec_alarm_clock;
  localparam int PERIOD = 10;
  localparam int CPS    = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // behavioural reference state
  logic [31:0] mCnt = '0, mAlarm = '0, mLoad = '0;
  int          mPre = 0;
  bit          mMask = 0, mStat = 0;

  always #(PERIOD/2) clk = ~clk;

  sec_alarm_clock #(.CLKS_PER_SEC(CPS)) i_sec_alarm_clock (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mAlarm = 0; mLoad = 0; mPre = 0; mMask = 0; mStat = 0;
    end else begin
      bit ld, al, event_, tk;
      ld = busWr && busAddr[11:2] == 10'd2;
      al = busWr && busAddr[11:2] == 10'd1;
      tk = !ld && (mPre == CPS - 1);
      if (ld) begin mCnt = busWdata; mLoad = busWdata; mPre = 0; end
      else if (tk) begin mCnt = mCnt + 1; mPre = 0; end
      else mPre = mPre + 1;
      if (al) mAlarm = busWdata;
      if (busWr && busAddr[11:2] == 10'd4) mMask = busWdata[0];
      event_ = ld || al || tk;
      if (event_ && mCnt == mAlarm) mStat = 1;
      else if (busWr && busAddr[11:2] == 10'd7) mStat = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // R10: interrupt compared with the model on every clock
  always @(negedge clk) begin
    if (rstN && !done)
      check(irqOut == (mStat & mMask), "R10 irq", 32'(irqOut), 32'(mStat & mMask));
  end

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a[11:2])
      10'd0: return mCnt;
      10'd1: return mAlarm;
      10'd2: return mLoad;
      10'd3: return 32'd1;
      10'd4: return 32'(mMask);
      10'd5: return 32'(mStat);
      10'd6: return 32'(mStat & mMask);
      default: return 32'd0;
    endcase
  endfunction

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readExp(input logic [11:0] a, input logic [31:0] exp, input string tag);
    busRd = 1'b1; busAddr = a;
    #(PERIOD/4);
    check(busRdata == exp, tag, busRdata, exp);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic readModel(input logic [11:0] a, input string tag);
    readExp(a, modelRead(a), tag);
  endtask

  initial begin
    repeat (PERIOD * 200000) #1;
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    readExp(12'h004, 0, "R1 alarm");
    readExp(12'h008, 0, "R1 load");
    readExp(12'h010, 0, "R1 mask");
    readExp(12'h014, 0, "R1 raw");
    check(irqOut == 1'b0, "R1 irq", 32'(irqOut), 0);

    // R3 + R2: load then tick spacing
    busWrite(12'h008, 32'd10);
    idle(3);
    readExp(12'h000, 32'd10, "R2 before tick");
    readExp(12'h000, 32'd11, "R2 after tick");
    readExp(12'h008, 32'd10, "R3 load readback");
    idle(9);
    readModel(12'h000, "R2 running count");

    // R4 alarm readback
    busWrite(12'h004, 32'hDEAD_BEEF);
    readExp(12'h004, 32'hDEAD_BEEF, "R4 alarm readback");

    // R8 mask bit 0 only
    busWrite(12'h010, 32'hFFFF_FFFE);
    readExp(12'h010, 0, "R8 mask even");
    busWrite(12'h010, 32'h0000_0003);
    readExp(12'h010, 1, "R8 mask odd");

    // R6 immediate compare on alarm write
    busWrite(12'h008, 32'd100);
    busWrite(12'h004, 32'd100);
    readExp(12'h014, 1, "R6 alarm write match");
    readExp(12'h018, 1, "R10 masked status");
    check(irqOut == 1'b1, "R10 irq high", 32'(irqOut), 1);

    // R9 clear with arbitrary data
    busWrite(12'h01C, 32'h1234_5670);
    readExp(12'h014, 0, "R9 clear any data");
    // R6 immediate compare on load write
    busWrite(12'h008, 32'd100);
    readExp(12'h014, 1, "R6 load write match");
    busWrite(12'h01C, 32'h0);

    // R10 masked off
    busWrite(12'h010, 32'h0);
    busWrite(12'h008, 32'd55);
    busWrite(12'h004, 32'd55);
    readExp(12'h018, 0, "R10 masked off");
    check(irqOut == 1'b0, "R10 irq masked", 32'(irqOut), 0);
    busWrite(12'h01C, 32'h0);
    busWrite(12'h010, 32'h1);

    // R5 wrap: count FFFFFFFF, alarm 0
    busWrite(12'h008, 32'hFFFF_FFFF);
    busWrite(12'h004, 32'h0);
    readExp(12'h014, 0, "R5 not yet");
    idle(2);
    readExp(12'h000, 32'h0, "R2 wrap to zero");
    readExp(12'h014, 1, "R5 match across wrap");
    busWrite(12'h01C, 32'h0);

    // R9 set wins over clear on the same edge
    busWrite(12'h008, 32'd7);
    busWrite(12'h004, 32'd8);
    idle(2);
    busWrite(12'h01C, 32'hFFFF_FFFF);
    readExp(12'h014, 1, "R9 set beats clear");
    busWrite(12'h01C, 32'h0);

    // R7 control
    busWrite(12'h00C, 32'h0);
    readExp(12'h00C, 1, "R7 control reads one");

    // R12 ignored writes
    busWrite(12'h000, 32'hAAAA_0000);
    busWrite(12'h014, 32'h1);
    busWrite(12'h018, 32'h1);
    busWrite(12'h200, 32'h1);
    readModel(12'h000, "R12 count untouched");
    readExp(12'h014, 0, "R12 raw untouched");
    readExp(12'h004, 32'd8, "R12 alarm untouched");
    readExp(12'h008, 32'd7, "R12 load untouched");
    readExp(12'h01C, 0, "R12 clear reads zero");
    readExp(12'h040, 0, "R12 unmapped reads zero");

    // R11 identification bytes
    begin
      logic [7:0] ids [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++)
        readExp(12'hFE0 + 12'(i * 4), 32'(ids[i]), "R11 id byte");
    end

    idle(2);
    done = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule